// File: doc/BRIEF.md
# Wake Event Status Mirror and Core Interrupt Mask

This block sits between a host power-management interface and an embedded core. Ring-indicator wake events set bits in two status registers at once: a primary wake-status register and a mirrored host copy. Software clears each copy on its own with write-one-to-clear, so clearing one copy never disturbs the other. A host-domain software reset clears only the mirrored copy.

The block also watches a set of control bits: six ACPI sleep-state request bits (S0 to S5), a power-button-mode bit and a power-supply-off bit. Any change of one of these bits sets a sticky pending flag. An interrupt mask register decides which pending flags, and whether the RTC alarm level, drive the single level-high interrupt to the core. The S0 change interrupt has no enable bit of its own. It is enabled whenever at least one of the S1 to S5 enables is set.

Software reaches four 8-bit registers through a simple port with a write strobe. Read data is registered and appears one clock after the address. The addresses are: 0 primary status, 1 mirrored status, 2 interrupt mask, 3 change-pending flags.

Top module: `wk_event_ctl`

## Requirements
- R1: After `rst` all four registers read 0x00 and `core_irq` is 0.
- R2: A pulse on `ev_ri1` sets bit 0, and a pulse on `ev_ri2` sets bit 1, in both the primary status (address 0) and the mirrored status (address 1).
- R3: A write to address 0 or 1 clears each status bit written as 1 and leaves each bit written as 0 unchanged. The other status copy is unaffected.
- R4: When an event strobe and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R5: A one-cycle `host_sw_rst` clears the mirrored status to 0x00 and leaves the primary status unchanged.
- R6: Bits 7:2 of both status registers read as 0, and writes to them have no effect.
- R7: With mask bit 7 set, `core_irq` is 1 on the clock after `rtc_alarm` is 1 and follows it back to 0. With mask bit 7 clear, the alarm raises no interrupt.
- R8: A change of `acpi_req[i]` for i = 1..5 sets pending bit i at address 3. That flag stays set until 1 is written to it. It raises `core_irq` when mask bit i-1 is set.
- R9: A change of `acpi_req[0]` sets pending bit 0. That flag raises `core_irq` when any of mask bits 4:0 is set.
- R10: A change of `pbm_bit` sets pending bit 6, enabled by mask bit 5. A change of `pso_bit` sets pending bit 7, enabled by mask bit 6.
- R11: A pending flag whose enable is clear raises no interrupt. It does drive `core_irq` once its enable is later set.
- R12: `core_irq` is registered. A control-bit change driven before clock edge k sets the pending flag at edge k and raises `core_irq` at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| host_sw_rst | input | 1 | Host-domain software reset, clears the mirrored status |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| ev_ri1 | input | 1 | Ring indicator 1 event strobe |
| ev_ri2 | input | 1 | Ring indicator 2 event strobe |
| rtc_alarm | input | 1 | RTC alarm level |
| acpi_req | input | 6 | Sleep-state request bits, index i is Si |
| pbm_bit | input | 1 | Power-button-mode control bit |
| pso_bit | input | 1 | Power-supply-off control bit |
| core_irq | output | 1 | Level-high interrupt to the core |

## Verification
The assertions check several rules on every cycle:
- Events always set both status copies.
- A status or pending bit never drops unless 1 is written to it or a reset occurs.
- The software reset empties the mirror.
- An all-zero mask always silences the interrupt one clock later.
- An enabled alarm raises it.

Other behaviours only the bench's directed scenarios can show:
- The bit positions of each source.
- The S0 enable implied by the S1 to S5 enables.
- The priority of an event over a simultaneous clear.
- The two-clock delay from a control-bit change to the interrupt.
- A stale pending flag firing once its enable is later set.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam logic [AW-1:0] ADDR_PRIMARY = 2'd0;
  localparam logic [AW-1:0] ADDR_MIRROR  = 2'd1;
  localparam logic [AW-1:0] ADDR_MASK    = 2'd2;
  localparam logic [AW-1:0] ADDR_PEND    = 2'd3;
  // mask register layout
  localparam int MSK_PBM = 5;
  localparam int MSK_PSO = 6;
  localparam int MSK_RTC = 7;
  // pending register layout: bits 5:0 sleep requests S0..S5
  localparam int PND_PBM = 6;
  localparam int PND_PSO = 7;
endpackage

// File: rtl/wk_w1c_reg.sv
module wk_w1c_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] w1c_i,
  output logic [W-1:0] q
);
  // set wins over a same-cycle clear; resets win over everything
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else            q <= (q & ~w1c_i) | set_i;
  end
endmodule

// File: rtl/wk_change_det.sv
module wk_change_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mon_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;

  // sampled during reset too, so the first cycle after reset sees no change
  always_ff @(posedge clk) prev_q <= mon_i;

  assign chg_o = rst ? '0 : (mon_i ^ prev_q);
endmodule

// File: rtl/wk_irq_combine.sv
module wk_irq_combine
  import wk_pkg::*;
#(
  parameter int N_SLEEP = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] pend_i,
  input  logic          rtc_alarm,
  output logic          irq_o
);
  localparam int N_SEN = N_SLEEP - 1;
  logic [DW-1:0] en_vec;

  // S0 has no enable of its own: any S1..S5 enable arms it
  assign en_vec[0] = |mask_i[N_SEN-1:0];
  for (genvar i = 1; i < N_SLEEP; i++) begin : g_sleep_en
    assign en_vec[i] = mask_i[i-1];
  end
  assign en_vec[PND_PBM] = mask_i[MSK_PBM];
  assign en_vec[PND_PSO] = mask_i[MSK_PSO];

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (|(pend_i & en_vec)) | (rtc_alarm & mask_i[MSK_RTC]);
  end
endmodule

// File: rtl/wk_event_ctl.sv
module wk_event_ctl
  import wk_pkg::*;
#(
  parameter int N_EV    = 2,
  parameter int N_SLEEP = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sw_rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_ri1,
  input  logic          ev_ri2,
  input  logic          rtc_alarm,
  input  logic [N_SLEEP-1:0] acpi_req,
  input  logic          pbm_bit,
  input  logic          pso_bit,
  output logic          core_irq
);
  localparam int N_MON = N_SLEEP + 2;

  logic [N_EV-1:0]  ev_vec;
  logic [N_EV-1:0]  primary_q, mirror_q;
  logic [N_EV-1:0]  primary_w1c, mirror_w1c;
  logic [DW-1:0]    mask_q;
  logic [N_MON-1:0] mon_vec, chg_vec, pend_q, pend_w1c;

  assign ev_vec  = {ev_ri2, ev_ri1};
  assign mon_vec = {pso_bit, pbm_bit, acpi_req};

  assign primary_w1c = (reg_we && reg_addr == ADDR_PRIMARY) ? reg_wdata[N_EV-1:0] : '0;
  assign mirror_w1c  = (reg_we && reg_addr == ADDR_MIRROR)  ? reg_wdata[N_EV-1:0] : '0;
  assign pend_w1c    = (reg_we && reg_addr == ADDR_PEND)    ? reg_wdata[N_MON-1:0] : '0;

  wk_w1c_reg #(.W(N_EV)) u_primary (
    .clk(clk), .rst(rst), .clr(1'b0),
    .set_i(ev_vec), .w1c_i(primary_w1c), .q(primary_q)
  );

  wk_w1c_reg #(.W(N_EV)) u_mirror (
    .clk(clk), .rst(rst), .clr(host_sw_rst),
    .set_i(ev_vec), .w1c_i(mirror_w1c), .q(mirror_q)
  );

  wk_change_det #(.W(N_MON)) u_chg (
    .clk(clk), .rst(rst), .mon_i(mon_vec), .chg_o(chg_vec)
  );

  wk_w1c_reg #(.W(N_MON)) u_pend (
    .clk(clk), .rst(rst), .clr(1'b0),
    .set_i(chg_vec), .w1c_i(pend_w1c), .q(pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                                   mask_q <= '0;
    else if (reg_we && reg_addr == ADDR_MASK)  mask_q <= reg_wdata;
  end

  wk_irq_combine #(.N_SLEEP(N_SLEEP)) u_irq (
    .clk(clk), .rst(rst), .mask_i(mask_q), .pend_i(pend_q),
    .rtc_alarm(rtc_alarm), .irq_o(core_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        ADDR_PRIMARY: reg_rdata <= {{(DW-N_EV){1'b0}}, primary_q};
        ADDR_MIRROR:  reg_rdata <= {{(DW-N_EV){1'b0}}, mirror_q};
        ADDR_MASK:    reg_rdata <= mask_q;
        default:      reg_rdata <= pend_q;
      endcase
    end
  end
endmodule

// File: rtl/wk_event_ctl_chk.sv
module wk_event_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_sw_rst,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       ev_ri1,
  input logic       ev_ri2,
  input logic       rtc_alarm,
  input logic       core_irq,
  input logic [1:0] primary_q,
  input logic [1:0] mirror_q,
  input logic [7:0] mask_q,
  input logic [7:0] pend_q
);
  p_irq_low_after_reset_r1: assert property (@(posedge clk) rst |=> !core_irq);

  p_ri1_sets_both_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_ri1 && !host_sw_rst) |=> (primary_q[0] && mirror_q[0]));

  p_ri2_sets_both_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_ri2 && !host_sw_rst) |=> (primary_q[1] && mirror_q[1]));

  p_primary_holds_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == 2'd0) |=> (($past(primary_q) & ~primary_q) == 2'b00));

  p_mirror_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!host_sw_rst && !(reg_we && reg_addr == 2'd1)) |=> (($past(mirror_q) & ~mirror_q) == 2'b00));

  p_swrst_clears_mirror_r5: assert property (@(posedge clk) disable iff (rst)
    host_sw_rst |=> (mirror_q == 2'b00));

  p_rtc_raises_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (rtc_alarm && mask_q[7]) |=> core_irq);

  p_pending_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == 2'd3) |=> (($past(pend_q) & ~pend_q) == 8'h00));

  p_masked_silent_r11: assert property (@(posedge clk) disable iff (rst)
    (mask_q == 8'h00) |=> !core_irq);
endmodule

bind wk_event_ctl wk_event_ctl_chk u_chk (
  .clk(clk), .rst(rst), .host_sw_rst(host_sw_rst),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ev_ri1(ev_ri1), .ev_ri2(ev_ri2), .rtc_alarm(rtc_alarm),
  .core_irq(core_irq), .primary_q(primary_q), .mirror_q(mirror_q),
  .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/sim_wk_event_ctl.sv
module sim_wk_event_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_sw_rst = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ev_ri1 = 1'b0, ev_ri2 = 1'b0, rtc_alarm = 1'b0;
  logic [5:0] acpi_req = 6'b000000;
  logic       pbm_bit = 1'b0, pso_bit = 1'b0;
  logic       core_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wk_event_ctl u0 (
    .clk(clk), .rst(rst), .host_sw_rst(host_sw_rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_ri1(ev_ri1), .ev_ri2(ev_ri2),
    .rtc_alarm(rtc_alarm), .acpi_req(acpi_req), .pbm_bit(pbm_bit),
    .pso_bit(pso_bit), .core_irq(core_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all helper tasks start and end at a negative edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 register after reset", d, 8'h00);
    end
    chk("R1 irq after reset", {7'b0, core_irq}, 8'h00);
  endtask

  task automatic t_events();
    logic [7:0] d;
    ev_ri1 = 1'b1; @(negedge clk); ev_ri1 = 1'b0;
    rd(2'd0, d); chk("R2 ri1 primary", d, 8'h01);
    rd(2'd1, d); chk("R2 ri1 mirror", d, 8'h01);
    ev_ri2 = 1'b1; @(negedge clk); ev_ri2 = 1'b0;
    rd(2'd0, d); chk("R2 ri2 primary", d, 8'h03);
    rd(2'd1, d); chk("R2 ri2 mirror", d, 8'h03);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R3 zero write keeps mirror", d, 8'h03);
    wr(2'd1, 8'h01);
    rd(2'd1, d); chk("R3 mirror bit0 cleared", d, 8'h02);
    rd(2'd0, d); chk("R3 primary untouched", d, 8'h03);
    wr(2'd0, 8'h02);
    rd(2'd0, d); chk("R3 primary bit1 cleared", d, 8'h01);
    rd(2'd1, d); chk("R3 mirror untouched", d, 8'h02);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    wr(2'd0, 8'hFC);
    rd(2'd0, d); chk("R6 reserved write ignored", d, 8'h01);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    ev_ri2 = 1'b1;
    wr(2'd1, 8'h02);
    ev_ri2 = 1'b0;
    rd(2'd1, d); chk("R4 event beats clear", d, 8'h02);
  endtask

  task automatic t_sw_reset();
    logic [7:0] d;
    host_sw_rst = 1'b1; @(negedge clk); host_sw_rst = 1'b0;
    rd(2'd1, d); chk("R5 mirror cleared", d, 8'h00);
    rd(2'd0, d); chk("R5 primary kept", d, 8'h03);
  endtask

  task automatic t_rtc();
    rtc_alarm = 1'b1; idle(1);
    chk("R7 alarm masked", {7'b0, core_irq}, 8'h00);
    wr(2'd2, 8'h80); idle(1);
    chk("R7 alarm enabled irq", {7'b0, core_irq}, 8'h01);
    rtc_alarm = 1'b0; idle(1);
    chk("R7 irq follows alarm low", {7'b0, core_irq}, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_sleep_change();
    logic [7:0] d;
    wr(2'd2, 8'h02);                // S2 enable
    acpi_req[2] = 1'b1;
    @(negedge clk);
    chk("R12 irq not yet", {7'b0, core_irq}, 8'h00);
    @(negedge clk);
    chk("R12 irq second edge", {7'b0, core_irq}, 8'h01);
    idle(3);
    chk("R8 irq sticky", {7'b0, core_irq}, 8'h01);
    rd(2'd3, d); chk("R8 pending bit2", d, 8'h04);
    wr(2'd3, 8'h04); idle(1);
    chk("R8 irq cleared", {7'b0, core_irq}, 8'h00);
    acpi_req[3] = 1'b1; idle(3);
    chk("R8 other sleep bit masked", {7'b0, core_irq}, 8'h00);
    rd(2'd3, d); chk("R8 pending bit3", d, 8'h08);
    wr(2'd3, 8'h08); wr(2'd2, 8'h00);
  endtask

  task automatic t_s0_implied();
    wr(2'd2, 8'h10);                // only S5 enable
    acpi_req[0] = 1'b1; idle(2);
    chk("R9 S0 via S5 enable", {7'b0, core_irq}, 8'h01);
    wr(2'd3, 8'h01); idle(1);
    chk("R9 S0 cleared", {7'b0, core_irq}, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_pbm_pso_masked();
    logic [7:0] d;
    pbm_bit = 1'b1; idle(3);
    chk("R11 masked pbm silent", {7'b0, core_irq}, 8'h00);
    rd(2'd3, d); chk("R10 pbm pending bit6", d, 8'h40);
    wr(2'd2, 8'h20); idle(1);
    chk("R11 stale pending fires", {7'b0, core_irq}, 8'h01);
    wr(2'd3, 8'h40); wr(2'd2, 8'h40);
    pso_bit = 1'b1; idle(2);
    chk("R10 pso irq", {7'b0, core_irq}, 8'h01);
    rd(2'd3, d); chk("R10 pso pending bit7", d, 8'h80);
    wr(2'd3, 8'h80); idle(1);
    chk("R10 pso cleared", {7'b0, core_irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_events();
    t_w1c();
    t_reserved();
    t_collision();
    t_sw_reset();
    t_rtc();
    t_sleep_change();
    t_s0_implied();
    t_pbm_pso_masked();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule